// File: doc/BRIEF.md
# Context-Aware L1 Load Access Sequencer

This block sequences one load at a time into a 4-way set-associative L1 data cache (16 KiB, 32-byte lines, 128 sets) whose 16-entry fully associative translation buffer is looked up together with the tag arrays. Every load instruction carries a 2-bit access hint in its memory-info field. The block decodes the hint and picks one of four access styles. The first is a conventional access, where an address-generation cycle is followed by a single cycle that reads every tag and data way in parallel. The second skips address generation when the offset is zero. The third is a phased tag-then-data access, and the fourth is an early tag access for loads whose consumer is at least three instructions away.

Each cycle the block drives the address-generation enable and bypass, the translation and tag lookup enables, one enable per data way and a stall request. It also pulses a result-ready strobe in the cycle the load data is available. The tag and translation results come back in the same cycle as the lookup enables. A miss in any style suppresses the data reads. The block then holds a miss output and a stall request until a refill-done pulse arrives. The arrays, the translation contents and the refill engine live outside the block.

Top module: `ctxld_seq`

## Requirements
- R1: The hint is bits [15:14] of the 16-bit memory field, and the immediate offset is bits [13:0]. Hint encoding: 00 parallel, 01 address-generation bypass, 10 phased, 11 early tag.
- R2: A bypass hint with a non-zero immediate is executed exactly as a parallel access.
- R3: A parallel load hit has address generation in its accept cycle. In the next cycle it has one translation lookup, one tag lookup and all four data-way enables, with result-ready in that cycle and no stall.
- R4: A bypass load hit asserts agu_bypass with agu_en low. Its lookups and all four data-way enables occur in the accept cycle, and result-ready is in that same cycle.
- R5: A phased load hit has address generation in the accept cycle and the lookups in the next cycle with no data-way enable. The cycle after that enables only the hitting way, pulses result-ready and raises stall_req for that one cycle.
- R6: An early-tag load hit follows the phased cycle pattern and reads only the hitting way, with stall_req never raised.
- R7: A lookup with a translation miss or no tag hit enables no data way. From the next cycle, miss and stall_req stay high up to and including the cycle in which refill_done is seen. result-ready pulses in that cycle and the block then returns to idle.
- R8: ld_ready is low from the cycle after acceptance until the load completes, and ld_valid in that period starts no new load.
- R9: refill_done outside a miss wait has no effect on any output.
- R10: After reset the block is idle: ld_ready high and every enable, stall, miss and ready output low.
- R11: When several tag ways report a hit, the lowest-numbered one is the way read in the phased and early-tag data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is offered this cycle |
| ld_field | input | 16 | Memory-info hint and immediate half of the load encoding |
| tlb_hit | input | 1 | Translation lookup hit, valid while tlb_en is high |
| tag_hit | input | 4 | Per-way tag match, valid while tag_en is high |
| refill_done | input | 1 | Refill finished pulse |
| ld_ready | output | 1 | Block idle and able to accept a load |
| agu_en | output | 1 | Address-generation unit active |
| agu_bypass | output | 1 | Base register used directly as the address |
| tlb_en | output | 1 | Translation buffer lookup enable |
| tag_en | output | 1 | Tag arrays read enable |
| data_way_en | output | 4 | Per-way data array read enable |
| stall_req | output | 1 | Pipeline stall request |
| miss | output | 1 | Load is waiting for a refill |
| data_ready | output | 1 | Load result available this cycle |

## Verification
The bench counts, for every load, the address-generation cycles, lookups, data-way reads, stall cycles and result latency, and compares them with a model of each access style. A decoder that ignored the immediate on a bypass hint would finish a non-zero-offset load a cycle early with no address generation. A sequencer that speculated in the phased style would show four data reads instead of one. Miss loads with varied refill delays catch a design that enables ways on a miss or leaves the wait early. Loads offered while busy and stray refill pulses while idle catch a design that accepts either.

// File: rtl/ctxld_pkg.sv
package ctxld_pkg;

    typedef enum logic [1:0] {
        AM_PARALLEL = 2'b00,
        AM_NOAGU    = 2'b01,
        AM_PHASED   = 2'b10,
        AM_EARLYTAG = 2'b11
    } acc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DATA,
        ST_WAIT
    } seq_st_e;

endpackage

// File: rtl/ctxld_hint_dec.sv
module ctxld_hint_dec
    import ctxld_pkg::*;
#(
    parameter int FIELD_W = 16,
    parameter int HINT_X  = 0
) (
    input  logic [FIELD_W-1:0] field,
    output acc_mode_e          mode
);
    localparam int IMM_W   = FIELD_W - 2 - HINT_X;
    localparam int HINT_HI = FIELD_W - 1;

    logic [1:0] raw_hint;
    logic       imm_zero;

    always_comb begin
        raw_hint = field[HINT_HI -: 2];
        imm_zero = (field[IMM_W-1:0] == '0);
        // R2: offset-free addressing only when the offset really is zero
        if (acc_mode_e'(raw_hint) == AM_NOAGU && !imm_zero)
            mode = AM_PARALLEL;
        else
            mode = acc_mode_e'(raw_hint);
    end
endmodule

// File: rtl/ctxld_way_pick.sv
module ctxld_way_pick #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0] hits,
    output logic [WAYS-1:0] first,
    output logic            any
);
    logic [WAYS:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < WAYS; i++) begin : g_way
            assign first[i]  = hits[i] & ~seen[i];
            assign seen[i+1] = seen[i] | hits[i];
        end
    endgenerate

    assign any = seen[WAYS];
endmodule

// File: rtl/ctxld_seq.sv
module ctxld_seq
    import ctxld_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int FIELD_W = 16,
    parameter int HINT_X  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic [FIELD_W-1:0] ld_field,
    input  logic               tlb_hit,
    input  logic [WAYS-1:0]    tag_hit,
    input  logic               refill_done,
    output logic               ld_ready,
    output logic               agu_en,
    output logic               agu_bypass,
    output logic               tlb_en,
    output logic               tag_en,
    output logic [WAYS-1:0]    data_way_en,
    output logic               stall_req,
    output logic               miss,
    output logic               data_ready
);
    typedef struct packed {
        seq_st_e         st;
        acc_mode_e       mode;
        logic [WAYS-1:0] way;
    } seq_t;

    seq_t      seq_d, seq_q;
    acc_mode_e dec_mode;
    acc_mode_e act_mode;
    logic [WAYS-1:0] hit_first;
    logic            hit_any;
    logic            lookup_now;

    ctxld_hint_dec #(.FIELD_W(FIELD_W), .HINT_X(HINT_X)) u_dec (
        .field (ld_field),
        .mode  (dec_mode)
    );

    ctxld_way_pick #(.WAYS(WAYS)) u_pick (
        .hits  (tag_hit),
        .first (hit_first),
        .any   (hit_any)
    );

    always_comb begin
        seq_d       = seq_q;
        ld_ready    = 1'b0;
        agu_en      = 1'b0;
        agu_bypass  = 1'b0;
        tlb_en      = 1'b0;
        tag_en      = 1'b0;
        data_way_en = '0;
        stall_req   = 1'b0;
        miss        = 1'b0;
        data_ready  = 1'b0;
        lookup_now  = 1'b0;
        act_mode    = seq_q.mode;

        case (seq_q.st)
            ST_IDLE: begin
                ld_ready = 1'b1;
                if (ld_valid) begin
                    seq_d.mode = dec_mode;
                    act_mode   = dec_mode;
                    if (dec_mode == AM_NOAGU) begin
                        agu_bypass = 1'b1;
                        lookup_now = 1'b1;
                    end else begin
                        agu_en   = 1'b1;
                        seq_d.st = ST_LOOKUP;
                    end
                end
            end
            ST_LOOKUP: lookup_now = 1'b1;
            ST_DATA: begin
                data_way_en = seq_q.way;
                data_ready  = 1'b1;
                stall_req   = (seq_q.mode == AM_PHASED);
                seq_d.st    = ST_IDLE;
            end
            default: begin
                miss      = 1'b1;
                stall_req = 1'b1;
                if (refill_done) begin
                    data_ready = 1'b1;
                    seq_d.st   = ST_IDLE;
                end
            end
        endcase

        if (lookup_now) begin
            tlb_en = 1'b1;
            tag_en = 1'b1;
            if (!(tlb_hit && hit_any)) begin
                seq_d.st = ST_WAIT;
            end else if (act_mode == AM_PARALLEL || act_mode == AM_NOAGU) begin
                data_way_en = '1;
                data_ready  = 1'b1;
                seq_d.st    = ST_IDLE;
            end else begin
                seq_d.way = hit_first;
                seq_d.st  = ST_DATA;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.mode <= AM_PARALLEL;
            seq_q.way  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_BYPASS_NO_AGU: assert property (@(posedge clk) disable iff (!rst_n)
        agu_bypass |-> (!agu_en && tag_en && tlb_en)); // R4

    AST_DATA_AFTER_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_way_en && !tag_en) |-> $past(tag_en)); // R5

    AST_SINGLE_WAY_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_way_en && !tag_en) |-> $onehot(data_way_en)); // R6

    AST_NO_READ_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_en && !tlb_hit) |-> (data_way_en == '0)); // R7

    AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !refill_done) |=> (miss && stall_req)); // R7

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ready) |-> !(agu_en || agu_bypass)); // R8
endmodule

// File: tb/ctxld_seq_bench.sv
module ctxld_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_field = '0;
    logic        tlb_hit = 1'b0;
    logic [3:0]  tag_hit = '0;
    logic        refill_done = 1'b0;
    logic        ld_ready, agu_en, agu_bypass, tlb_en, tag_en;
    logic [3:0]  data_way_en;
    logic        stall_req, miss, data_ready;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    ctxld_seq u_ctxld_seq (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_field(ld_field),
        .tlb_hit(tlb_hit), .tag_hit(tag_hit), .refill_done(refill_done),
        .ld_ready(ld_ready), .agu_en(agu_en), .agu_bypass(agu_bypass),
        .tlb_en(tlb_en), .tag_en(tag_en), .data_way_en(data_way_en),
        .stall_req(stall_req), .miss(miss), .data_ready(data_ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lowest_way(input logic [3:0] h);
        for (int i = 0; i < 4; i++) if (h[i]) return (1 << i);
        return 0;
    endfunction

    // One load: hint in bits [15:14], immediate in [13:0] (R1)
    task automatic run_load(input logic [1:0] hint, input logic [13:0] imm,
                            input logic tlbh, input logic [3:0] tagh,
                            input int wait_n, input bit hold);
        int eff, t_lk, e_ready, e_data, e_way, e_stall, e_miss;
        int cyc, c_agu, c_byp, c_tlb, c_tag, c_data, c_stall, c_miss, c_busy_rdy, way_or;
        int ready_at;
        bit hit;
        string req;
        eff  = (hint == 2'b01 && imm != 0) ? 0 : int'(hint);
        hit  = tlbh && (tagh != 0);
        t_lk = (eff == 1) ? 0 : 1;
        if (hit) begin
            e_ready = (eff <= 1) ? t_lk : t_lk + 1;
            e_data  = (eff <= 1) ? 4 : 1;
            e_way   = (eff <= 1) ? 15 : lowest_way(tagh);
            e_stall = (eff == 2) ? 1 : 0;
            e_miss  = 0;
        end else begin
            e_ready = t_lk + 1 + wait_n;
            e_data  = 0;
            e_way   = 0;
            e_stall = wait_n + 1;
            e_miss  = wait_n + 1;
        end
        if (!hit)           req = "R7";
        else if (eff == 0)  req = (hint == 2'b01) ? "R2" : "R3";
        else if (eff == 1)  req = "R4";
        else if (eff == 2)  req = "R5";
        else                req = "R6";

        c_agu = 0; c_byp = 0; c_tlb = 0; c_tag = 0; c_data = 0; c_stall = 0;
        c_miss = 0; c_busy_rdy = 0; way_or = 0; ready_at = -1;
        tlb_hit = tlbh; tag_hit = tagh;
        for (cyc = 0; cyc < 40; cyc++) begin
            @(negedge clk);
            ld_valid    = (cyc == 0) || hold;
            ld_field    = {hint, imm};
            refill_done = (c_miss >= wait_n) && (c_miss > 0);
            #1;
            c_agu   += int'(agu_en);
            c_byp   += int'(agu_bypass);
            c_tlb   += int'(tlb_en);
            c_tag   += int'(tag_en);
            c_data  += $countones(data_way_en);
            way_or  |= int'(data_way_en);
            c_stall += int'(stall_req);
            c_miss  += int'(miss);
            if (cyc > 0) c_busy_rdy += int'(ld_ready);
            if (data_ready) begin
                ready_at = cyc;
                break;
            end
        end
        @(negedge clk);
        ld_valid = 1'b0; refill_done = 1'b0;
        if (ready_at < 0) begin
            n_checks++; n_errors++;
            $display("FAIL %s watchdog: actual=no result expected=result", req);
        end
        chk(req, "ready cycle", ready_at, e_ready);
        chk(req, "agu cycles", c_agu, (eff == 1) ? 0 : 1);
        chk(req, "bypass cycles", c_byp, (eff == 1) ? 1 : 0);
        chk(req, "tlb lookups", c_tlb, 1);
        chk(req, "tag reads", c_tag, 1);
        chk(req, "data way reads", c_data, e_data);
        chk(req, "ways read", way_or, e_way);
        chk(req, "stall cycles", c_stall, e_stall);
        chk(req, "miss cycles", c_miss, e_miss);
        chk("R8", "ld_ready while busy", c_busy_rdy, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk("R10", "ld_ready", int'(ld_ready), 1);
        chk("R10", "enables", int'({agu_en, agu_bypass, tlb_en, tag_en, data_way_en}), 0);
        chk("R10", "stall/miss/ready", int'({stall_req, miss, data_ready}), 0);

        // R9 stray refill while idle
        @(negedge clk);
        refill_done = 1'b1;
        #1;
        chk("R9", "ready on stray refill", int'(data_ready), 0);
        chk("R9", "miss on stray refill", int'(miss), 0);
        chk("R9", "idle kept", int'(ld_ready), 1);
        @(negedge clk);
        refill_done = 1'b0;

        // Directed corners
        run_load(2'b00, 14'd76, 1'b1, 4'b0100, 1, 1'b0); // R3
        run_load(2'b01, 14'd0,  1'b1, 4'b0001, 1, 1'b0); // R4
        run_load(2'b01, 14'd4,  1'b1, 4'b0010, 1, 1'b0); // R2
        run_load(2'b10, 14'd4,  1'b1, 4'b1000, 1, 1'b1); // R5, R8 held valid
        run_load(2'b11, 14'd4,  1'b1, 4'b0010, 1, 1'b0); // R6
        run_load(2'b10, 14'd8,  1'b1, 4'b1010, 1, 1'b0); // R11 lowest way
        run_load(2'b11, 14'd8,  1'b1, 4'b0110, 1, 1'b0); // R11 lowest way
        run_load(2'b00, 14'd8,  1'b0, 4'b0001, 3, 1'b1); // R7 tlb miss
        run_load(2'b01, 14'd0,  1'b1, 4'b0000, 2, 1'b0); // R7 tag miss on bypass

        // Constrained random loads
        for (int k = 0; k < 300; k++) begin
            logic [1:0]  h;
            logic [13:0] im;
            logic        th;
            logic [3:0]  tg;
            h  = 2'($urandom_range(0, 3));
            im = ($urandom_range(0, 1) == 0) ? 14'd0 : 14'($urandom_range(1, 255));
            th = ($urandom_range(0, 5) != 0);
            case ($urandom_range(0, 5))
                0:       tg = 4'b0000;
                1:       tg = 4'($urandom_range(1, 15));
                default: tg = 4'(1 << $urandom_range(0, 3));
            endcase
            run_load(h, im, th, tg, $urandom_range(1, 4), ($urandom_range(0, 1) == 1));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule